// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The block gathers a parameterized set of interrupt sources into one registered request line for a processor. Each source is configured on its own as edge-sensitive (a rising edge is latched until software acknowledges it) or level-sensitive (the source is pending for as long as it is held high). Every source can be masked on its own. When several sources are active at once, the lowest-numbered one is reported first.

Software reaches the block through a small register window with a combinational read path. A master control register has two bits. The output-enable bit gates the request line. The sticky arm bit hands control from software to hardware. Before the block is armed, hardware sources are ignored, and software can raise pending bits by writing the status register, for example to test the handler. After the block is armed, hardware sources drive the pending state and writes to the status register have no effect.

Register map (address, access): 0 status (read; write sets pending bits while unarmed), 1 enable (read/write), 2 acknowledge (write-1-to-clear, reads 0), 3 sensitivity (read/write, bit value 1 means edge), 4 master (bit 0 output enable, bit 1 arm), 5 vector (read only). Any other address reads 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the status, enable, sensitivity and master registers read 0, the vector reads all ones, and irq_out is 0.
- R2: On an armed edge-sensitive source, a 0-to-1 change of irq_src between two clock edges sets its status bit at the second edge. The bit stays set after the source drops.
- R3: An armed level-sensitive source shows in status for as long as it is high. An acknowledge does not remove it while it is high.
- R4: Writing address 2 clears each latched pending bit whose write-data bit is 1. Bits written as 0 are unaffected. A latched bit never clears without an acknowledge.
- R5: A source whose enable bit is 0 still shows in status but does not affect the vector or irq_out.
- R6: The vector returns the lowest index whose status and enable bits are both 1, or all ones when there is none.
- R7: irq_out, sampled at a clock edge, is the output-enable bit AND the OR of the enabled status bits, taken from the state before that edge.
- R8: While the output-enable bit is 0, irq_out is 0 from the next edge on.
- R9: While unarmed, writing address 0 sets the pending bits given by the ones in the write data, and hardware sources are ignored.
- R10: Once master bit 1 is written as 1, the block stays armed until reset. Writing it as 0 does not disarm the block, and writes to address 0 are ignored while armed.
- R11: If an acknowledge and a new edge on the same source land in the same cycle, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NUM_SRC | Interrupt sources, bit 0 highest priority |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that irq_src and the bus signals are stable around each rising edge, and that NUM_SRC does not exceed DATA_W. They also assume that only one register is written per cycle, which the single address port already ensures. The bench changes every input on the falling edge only and uses the default eight sources within a 32-bit word, so the edge detector sees each source transition exactly once.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SENS = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(5);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend_q, en_q, edge_q, src_q;
  logic               out_en_q, armed_q, irq_q;
  logic [NUM_SRC-1:0] wsrc, ack_vec, sw_set, hw_mask, rise, status, active;
  logic [DATA_W-1:0]  vec;
  logic               unused_hi;

  assign wsrc      = bus_wdata[NUM_SRC-1:0];
  assign unused_hi = ^bus_wdata;
  assign ack_vec   = (bus_we && bus_addr == A_ACK) ? wsrc : '0;
  assign sw_set    = (bus_we && bus_addr == A_STAT && !armed_q) ? wsrc : '0;
  assign hw_mask   = {NUM_SRC{armed_q}};
  assign rise      = irq_src & ~src_q & edge_q & hw_mask;
  assign status    = pend_q | (irq_src & ~edge_q & hw_mask);
  assign active    = status & en_q;
  assign irq_out   = irq_q;

  always_comb begin
    vec = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (active[i]) vec = DATA_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      en_q     <= '0;
      edge_q   <= '0;
      src_q    <= '0;
      out_en_q <= 1'b0;
      armed_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      src_q  <= irq_src;
      pend_q <= (pend_q & ~ack_vec) | rise | sw_set;
      irq_q  <= out_en_q & (|active);
      if (bus_we && bus_addr == A_ENA)  en_q   <= wsrc;
      if (bus_we && bus_addr == A_SENS) edge_q <= wsrc;
      if (bus_we && bus_addr == A_MST) begin
        out_en_q <= bus_wdata[0];
        armed_q  <= armed_q | bus_wdata[1];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = DATA_W'(status);
      A_ENA:   bus_rdata = DATA_W'(en_q);
      A_SENS:  bus_rdata = DATA_W'(edge_q);
      A_MST:   bus_rdata = DATA_W'({armed_q, out_en_q});
      A_VEC:   bus_rdata = vec;
      default: bus_rdata = '0;
    endcase
  end

  assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> (active[vec[IDX_W-1:0]] &&
      ((active & ((NUM_SRC'(1) << vec[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));

  assert_vec_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '1) |-> (active == '0));

  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(ack_vec)) & ~pend_q) == '0));

  assert_arm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  assert_no_sw_set_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_q |=> !irq_out);

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|active));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_NS = 10;
  localparam logic [2:0] STAT = 3'd0, ENA = 3'd1, ACK = 3'd2, SENS = 3'd3, MST = 3'd4, VEC = 3'd5;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [7:0]  src;
    logic        we;
    logic [2:0]  addr;
    logic [7:0]  wd;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{8'h00, 1'b1, ENA,  8'hFF, ENA,  32'hFF, 1'b0},
    '{8'h00, 1'b1, SENS, 8'h0F, SENS, 32'h0F, 1'b0},
    '{8'h00, 1'b1, STAT, 8'h20, STAT, 32'h20, 1'b0},
    '{8'h00, 1'b1, MST,  8'h01, VEC,  32'd5,  1'b0},
    '{8'h01, 1'b0, STAT, 8'h00, STAT, 32'h20, 1'b1},
    '{8'h01, 1'b1, ACK,  8'h20, STAT, 32'h00, 1'b1},
    '{8'h00, 1'b1, MST,  8'h03, VEC,  NONE,   1'b0},
    '{8'h04, 1'b0, STAT, 8'h00, STAT, 32'h04, 1'b0},
    '{8'h00, 1'b1, STAT, 8'hFF, STAT, 32'h04, 1'b1},
    '{8'h80, 1'b0, STAT, 8'h00, VEC,  32'd2,  1'b1},
    '{8'h80, 1'b1, ACK,  8'h84, STAT, 32'h80, 1'b1},
    '{8'h80, 1'b1, ENA,  8'h7F, VEC,  NONE,   1'b1},
    '{8'h80, 1'b0, STAT, 8'h00, STAT, 32'h80, 1'b0},
    '{8'h00, 1'b1, MST,  8'h00, MST,  32'h02, 1'b0}
  };
  localparam string TAG [NV] = '{"R5", "R2", "R9", "R6", "R9", "R4", "R6",
                                 "R2", "R10", "R3", "R3", "R5", "R5", "R10"};

  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq_out;
  logic [7:0]  irq_src = '0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  prio_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic w, input logic [2:0] a,
                      input logic [31:0] d, input logic [2:0] ra);
    irq_src = s; bus_we = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ra;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_src = '0; bus_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    do_reset();
    rd(STAT); chk("R1 status", bus_rdata, 32'h0);
    rd(ENA);  chk("R1 enable", bus_rdata, 32'h0);
    rd(SENS); chk("R1 sensitivity", bus_rdata, 32'h0);
    rd(MST);  chk("R1 master", bus_rdata, 32'h0);
    rd(VEC);  chk("R1 vector", bus_rdata, NONE);
    chk("R1 irq_out", {31'd0, irq_out}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].src, TBL[i].we, TBL[i].addr, {24'd0, TBL[i].wd}, TBL[i].ra);
      chk($sformatf("%s table %0d rdata", TAG[i], i), bus_rdata, TBL[i].exp);
      chk($sformatf("R7 table %0d irq_out", i), {31'd0, irq_out}, {31'd0, TBL[i].irq});
    end

    do_reset();
    step(8'h00, 1'b1, ENA,  32'hFF, SENS);
    step(8'h00, 1'b1, SENS, 32'hFF, MST);
    step(8'h00, 1'b1, MST,  32'h03, VEC);
    chk("R6 vector empty", bus_rdata, NONE);
    step(8'h0A, 1'b0, STAT, 32'h0, VEC);
    chk("R6 lowest of two", bus_rdata, 32'd1);
    chk("R7 one cycle later", {31'd0, irq_out}, 32'h0);
    step(8'h0A, 1'b0, STAT, 32'h0, VEC);
    chk("R7 irq raised", {31'd0, irq_out}, 32'h1);
    step(8'h00, 1'b0, STAT, 32'h0, STAT);
    chk("R2 held after drop", bus_rdata, 32'h0A);
    step(8'h02, 1'b1, ACK, 32'h02, STAT);
    chk("R11 set beats ack", bus_rdata, 32'h0A);
    step(8'h00, 1'b1, ACK, 32'h02, VEC);
    chk("R4 ack then R6 next", bus_rdata, 32'd3);
    step(8'h00, 1'b1, MST, 32'h02, MST);
    chk("R10 arm stays", bus_rdata, 32'h02);
    chk("R8 old enable still seen", {31'd0, irq_out}, 32'h1);
    step(8'h00, 1'b0, STAT, 32'h0, STAT);
    chk("R8 gated low", {31'd0, irq_out}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule